// File: doc/BRIEF.md
# Peripheral Clock-Enable Generator

This block turns one of four free-running source tick streams into a slower clock-enable strobe for a peripheral. The chosen stream is counted by two cascaded divide stages, so one strobe leaves the block for every `A × B` selected ticks, where `A` and `B` are two programmable 3-bit divisor codes. A gate bit can silence the channel. Software controls the channel through a small word-addressed register window and can read every field back, together with a sticky flag that records an invalid divisor setting.

Control is a three-state machine. `ST_COUNT` counts ticks and is also the reset state. `ST_STALL` holds the counters at zero because a divisor code is invalid. `ST_OFF` holds the counters at zero because the gate bit is set. The transitions are:

- `ST_COUNT → ST_OFF` and `ST_STALL → ST_OFF` when the gate bit becomes 1.
- `ST_OFF → ST_COUNT` or `ST_OFF → ST_STALL` when the gate bit returns to 0, depending on whether the divisors are valid.
- `ST_COUNT → ST_STALL` when a divisor becomes invalid.
- `ST_STALL → ST_COUNT` when both divisors become valid again.

The next state is computed from the register values being written, so the state and the registers change on the same edge.

A build parameter replaces the product divider with a single divider. That divider looks up one bit of the first field in a two-entry table.

Top module: `perclk_en_gen`

## Requirements
- R1: After reset, the source register (0x00, bits 1:0) reads 0. The divisor register (0x04, first code in bits 2:0, second code in bits 5:3) reads 9, which is both codes equal to 1. The gate register (0x14, bit 0) reads 0 and the status register (0x18, bit 0) reads 0. Every written field reads back as written.
- R2: Only ticks on the source input indexed by the source field advance the count. Ticks on the other three inputs have no effect.
- R3: With both codes in 1..6, the strobe is high on the selected tick that is the P-th, 2P-th, 3P-th and so on since counting last restarted, where P is the first code times the second code.
- R4: The strobe is a single-cycle pulse that appears combinationally in the same cycle as the selected tick that completes the count.
- R5: A code of 0 or 7 in either field keeps the strobe low. While the gate is open, it also sets the status flag one cycle later.
- R6: The status flag stays set until software writes 1 to status bit 0 while the divisors are valid. A clear issued while they are still invalid has no effect.
- R7: While the gate bit is 1, the strobe stays low and the counters are held at zero. After the bit is cleared, the first strobe falls on the P-th selected tick.
- R8: Any write to 0x00, 0x04 or 0x14 restarts the count from zero. A tick that arrives in the same cycle as that write is discarded and produces no strobe.
- R9: With SINGLE_DIV=1, bit 0 of the first code picks the ratio and the second code is ignored. With TABLE_HI=0, bit value 0 gives ÷1 and 1 gives ÷2. With TABLE_HI=1, bit value 0 gives ÷2 and 1 gives ÷4.
- R10: Reads of an unmapped address, such as 0x08 or 0x1C, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | NSRC | Source tick streams, one bit per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| clk_en_o | output | 1 | Peripheral clock-enable strobe |

## Verification
The assertions check four things on every cycle: a strobe always coincides with a tick on the selected source, nothing leaves the block while it is gated, invalid or being reconfigured, an invalid setting raises the flag, and the flag only falls on a clear request. Only the bench's scenarios can show the arithmetic. It sweeps every valid pair of codes with a pseudo-random tick pattern and predicts each strobe position from the product. That sweep also covers the restart after ungating, the discarded tick in a write cycle, the ratios of the table-driven variant and the read-back values.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_STALL = 2'd1,
        ST_OFF   = 2'd2
    } pcg_state_e;

    localparam int PCG_OFF_SRC  = 'h00;
    localparam int PCG_OFF_DIV  = 'h04;
    localparam int PCG_OFF_GATE = 'h14;
    localparam int PCG_OFF_STAT = 'h18;

    // A 3-bit code of 1..6 divides by itself; 0 and 7 decode to the invalid ratio 0.
    function automatic logic [2:0] pcg_code_to_div(input logic [2:0] code);
        return (code == 3'd0 || code == 3'd7) ? 3'd0 : code;
    endfunction

    // Two-entry ratio tables used by the single-stage build.
    function automatic logic [2:0] pcg_table_div(input logic pick, input logic hi_table);
        logic [2:0] r;
        if (hi_table) r = pick ? 3'd4 : 3'd2;
        else          r = pick ? 3'd2 : 3'd1;
        return r;
    endfunction

endpackage

// File: rtl/pcg_regfile.sv
module pcg_regfile
    import pcg_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 2,
    parameter int FLD_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stalled,
    output logic [SEL_W-1:0]  sel_q,
    output logic [FLD_W-1:0]  d1_q,
    output logic [FLD_W-1:0]  d2_q,
    output logic              dis_q,
    output logic [SEL_W-1:0]  sel_n,
    output logic [FLD_W-1:0]  d1_n,
    output logic [FLD_W-1:0]  d2_n,
    output logic              dis_n,
    output logic              cfg_wr,
    output logic              err_clr,
    output logic              err_q,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(PCG_OFF_SRC);
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(PCG_OFF_DIV);
    localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(PCG_OFF_GATE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(PCG_OFF_STAT);

    logic hit_src, hit_div, hit_gate;
    logic unused_wdata;

    assign hit_src  = wr && (addr == A_SRC);
    assign hit_div  = wr && (addr == A_DIV);
    assign hit_gate = wr && (addr == A_GATE);
    assign cfg_wr   = hit_src || hit_div || hit_gate;
    assign err_clr  = wr && (addr == A_STAT) && wdata[0];

    assign sel_n = hit_src  ? wdata[SEL_W-1:0]         : sel_q;
    assign d1_n  = hit_div  ? wdata[FLD_W-1:0]         : d1_q;
    assign d2_n  = hit_div  ? wdata[2*FLD_W-1:FLD_W]   : d2_q;
    assign dis_n = hit_gate ? wdata[0]                 : dis_q;

    assign unused_wdata = ^wdata[DATA_W-1:2*FLD_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            d1_q  <= FLD_W'(1);
            d2_q  <= FLD_W'(1);
            dis_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            sel_q <= sel_n;
            d1_q  <= d1_n;
            d2_q  <= d2_n;
            dis_q <= dis_n;
            // A live stall outranks a clear request.
            err_q <= (err_q & ~err_clr) | stalled;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_SRC:   rdata[SEL_W-1:0]   = sel_q;
            A_DIV:   rdata[2*FLD_W-1:0] = {d2_q, d1_q};
            A_GATE:  rdata[0]           = dis_q;
            A_STAT:  rdata[0]           = err_q;
            default: rdata              = '0;
        endcase
    end

endmodule

// File: rtl/pcg_stage.sv
module pcg_stage #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] div,
    output logic         last,
    output logic         wrap
);

    logic [W-1:0] cnt_q;

    assign last = (cnt_q == div - 1'b1);
    assign wrap = adv & last;

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (adv)    cnt_q <= last ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/pcg_fsm.sv
module pcg_fsm
    import pcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dis_n,
    input  logic valid_n,
    output logic counting,
    output logic stalled
);

    pcg_state_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_COUNT: begin
                if (dis_n)         state_n = ST_OFF;
                else if (!valid_n) state_n = ST_STALL;
            end
            ST_STALL: begin
                if (dis_n)         state_n = ST_OFF;
                else if (valid_n)  state_n = ST_COUNT;
            end
            ST_OFF: begin
                if (!dis_n)        state_n = valid_n ? ST_COUNT : ST_STALL;
            end
            default:               state_n = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_COUNT;
        else        state_q <= state_n;
    end

    always_comb begin
        counting = 1'b0;
        stalled  = 1'b0;
        unique case (state_q)
            ST_COUNT: counting = 1'b1;
            ST_STALL: stalled  = 1'b1;
            ST_OFF:   ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/perclk_en_gen.sv
module perclk_en_gen
    import pcg_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int NSRC       = 4,
    parameter int SINGLE_DIV = 0,
    parameter int TABLE_HI   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              clk_en_o
);

    localparam int SEL_W  = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int FLD_W  = 3;
    localparam int DATA_W = 32;

    logic [SEL_W-1:0] sel_q, sel_n;
    logic [FLD_W-1:0] d1_q, d2_q, d1_n, d2_n;
    logic             dis_q, dis_n, cfg_wr, err_clr, err_q;
    logic             counting, stalled, valid_n;
    logic [FLD_W-1:0] div_a, div_b;
    logic             sel_tick, adv_a, clr_cnt;
    logic             last_a, wrap_a, last_b, wrap_b;
    logic             unused_sel;

    pcg_regfile #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .FLD_W(FLD_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .stalled(stalled),
        .sel_q(sel_q), .d1_q(d1_q), .d2_q(d2_q), .dis_q(dis_q),
        .sel_n(sel_n), .d1_n(d1_n), .d2_n(d2_n), .dis_n(dis_n),
        .cfg_wr(cfg_wr), .err_clr(err_clr), .err_q(err_q), .rdata(reg_rdata)
    );

    assign unused_sel = ^sel_n;

    generate
        if (SINGLE_DIV != 0) begin : g_single
            logic unused_fields;
            assign div_a   = pcg_table_div(d1_q[0], TABLE_HI != 0);
            assign div_b   = FLD_W'(1);
            assign valid_n = 1'b1;
            assign unused_fields = ^{d1_q[FLD_W-1:1], d2_q, d1_n, d2_n};
        end else begin : g_double
            assign div_a   = pcg_code_to_div(d1_q);
            assign div_b   = pcg_code_to_div(d2_q);
            assign valid_n = (pcg_code_to_div(d1_n) != 3'd0) &&
                             (pcg_code_to_div(d2_n) != 3'd0);
        end
    endgenerate

    pcg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .dis_n(dis_n), .valid_n(valid_n),
        .counting(counting), .stalled(stalled)
    );

    assign sel_tick = src_tick[sel_q];
    assign adv_a    = sel_tick & counting & ~cfg_wr;
    assign clr_cnt  = cfg_wr | ~counting;

    pcg_stage #(.W(FLD_W)) u_stage_a (
        .clk(clk), .rst_n(rst_n), .clr(clr_cnt), .adv(adv_a), .div(div_a),
        .last(last_a), .wrap(wrap_a)
    );

    pcg_stage #(.W(FLD_W)) u_stage_b (
        .clk(clk), .rst_n(rst_n), .clr(clr_cnt), .adv(wrap_a), .div(div_b),
        .last(last_b), .wrap(wrap_b)
    );

    assign clk_en_o = wrap_b;

endmodule

// File: rtl/pcg_checker.sv
module pcg_checker #(
    parameter int NSRC       = 4,
    parameter int SEL_W      = 2,
    parameter int SINGLE_DIV = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  src_tick,
    input logic [SEL_W-1:0] sel_q,
    input logic [2:0]       d1_q,
    input logic [2:0]       d2_q,
    input logic             dis_q,
    input logic             cfg_wr,
    input logic             err_clr,
    input logic             err_q,
    input logic             stalled,
    input logic             strobe
);

    logic bad_code;
    assign bad_code = (SINGLE_DIV == 0) &&
                      (d1_q == 3'd0 || d1_q == 3'd7 || d2_q == 3'd0 || d2_q == 3'd7);

    p_strobe_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> src_tick[sel_q]);

    p_invalid_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bad_code |-> !strobe);

    p_stall_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |=> err_q);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clr) |=> err_q);

    p_gated_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dis_q |-> !strobe);

    p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> !strobe);

endmodule

bind perclk_en_gen pcg_checker #(
    .NSRC(NSRC), .SEL_W(SEL_W), .SINGLE_DIV(SINGLE_DIV)
) u_pcg_checker (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .sel_q(sel_q),
    .d1_q(d1_q), .d2_q(d2_q), .dis_q(dis_q), .cfg_wr(cfg_wr),
    .err_clr(err_clr), .err_q(err_q), .stalled(stalled), .strobe(clk_en_o)
);

// File: tb/tb_perclk_en_gen.sv
module tb_perclk_en_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata_d, rdata_s;
    logic        strobe_d, strobe_s;

    int tests = 0;
    int fails = 0;
    int k1 = 0, k2 = 0;
    int sel_m = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perclk_en_gen #(.SINGLE_DIV(0)) dut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_d), .clk_en_o(strobe_d)
    );

    perclk_en_gen #(.SINGLE_DIV(1), .TABLE_HI(1)) dut_single (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_s), .clk_en_o(strobe_s)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write one register; optionally raise every tick input during the write cycle.
    task automatic wr(input int addr, input int data, input bit tick);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(addr); reg_wdata = data;
        src_tick = tick ? 4'hF : 4'h0;
        #1;
        chk(strobe_d == 1'b0, "R8 tick in write cycle", strobe_d, 0);
        chk(strobe_s == 1'b0, "R8 tick in write cycle (single)", strobe_s, 0);
        @(negedge clk);
        reg_wr = 1'b0; src_tick = 4'h0;
        if (addr == 'h00) sel_m = data & 3;
        if (addr == 'h00 || addr == 'h04 || addr == 'h14) begin k1 = 0; k2 = 0; end
    endtask

    task automatic rd(input int addr, output int val_d);
        @(negedge clk);
        reg_addr = 5'(addr); src_tick = 4'h0;
        #1;
        val_d = rdata_d;
    endtask

    // Drive n cycles of ticks and compare both strobes with the modelled counts.
    task automatic run(input int n, input int p1, input int p2,
                       input bit en1, input bit en2, input bit dense);
        for (int i = 0; i < n; i++) begin
            bit t, e1, e2;
            @(negedge clk);
            src_tick = dense ? 4'hF : lfsr[3:0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            #1;
            t  = src_tick[sel_m];
            e1 = en1 && t && (k1 + 1 == p1);
            e2 = en2 && t && (k2 + 1 == p2);
            chk(strobe_d == e1, "R3 strobe position", strobe_d, e1);
            chk(strobe_s == e2, "R9 single-stage strobe position", strobe_s, e2);
            if (en1 && t) k1 = (k1 + 1 == p1) ? 0 : k1 + 1;
            if (en2 && t) k2 = (k2 + 1 == p2) ? 0 : k2 + 1;
        end
        @(negedge clk);
        src_tick = 4'h0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R10 unmapped reads
        rd('h00, v); chk(v == 0, "R1 source reset", v, 0);
        rd('h04, v); chk(v == 9, "R1 divisor reset", v, 9);
        chk(rdata_s == 9, "R1 divisor reset (single)", rdata_s, 9);
        rd('h14, v); chk(v == 0, "R1 gate reset", v, 0);
        rd('h18, v); chk(v == 0, "R1 status reset", v, 0);
        rd('h1C, v); chk(v == 0, "R10 unmapped read 0x1C", v, 0);
        rd('h08, v); chk(v == 0, "R10 unmapped read 0x08", v, 0);

        // R9 reset ratio of the single-stage build: bit 1 on the high table gives /4
        run(20, 1, 4, 1, 1, 0);

        // R2/R3/R4 sweep over every valid code pair
        for (int a = 1; a <= 6; a++) begin
            for (int b = 1; b <= 6; b++) begin
                int p, ps;
                p  = a * b;
                ps = (a % 2 == 1) ? 4 : 2;
                wr('h00, (a + b) % 4, 0);
                wr('h04, (b << 3) | a, 0);
                rd('h04, v); chk(v == ((b << 3) | a), "R1 divisor readback", v, (b << 3) | a);
                rd('h00, v); chk(v == (a + b) % 4, "R1 source readback", v, (a + b) % 4);
                run(6 * p + 4, p, ps, 1, 1, 0);
            end
        end
        // R4 back-to-back strobes when the ratio is 1
        wr('h04, (1 << 3) | 1, 0);
        run(8, 1, 4, 1, 1, 1);

        // R8 tick during a reconfiguration write is discarded and the count restarts
        wr('h00, 1, 0);
        wr('h04, (2 << 3) | 2, 0);
        run(3, 4, 2, 1, 1, 1);
        wr('h04, (2 << 3) | 2, 1);
        run(9, 4, 2, 1, 1, 1);

        // R7 gate
        wr('h14, 1, 0);
        rd('h14, v); chk(v == 1, "R7 gate readback", v, 1);
        run(40, 4, 2, 0, 0, 0);
        wr('h14, 0, 0);
        run(20, 4, 2, 1, 1, 1);

        // R5 invalid codes, R6 sticky flag
        wr('h04, (3 << 3) | 0, 0);
        run(30, 1, 2, 0, 1, 0);
        rd('h18, v); chk(v == 1, "R5 flag after code 0", v, 1);
        wr('h18, 1, 0);
        rd('h18, v); chk(v == 1, "R6 clear ignored while invalid", v, 1);
        wr('h04, (2 << 3) | 7, 0);
        run(30, 1, 4, 0, 1, 0);
        wr('h04, (7 << 3) | 3, 0);
        run(30, 1, 4, 0, 1, 0);
        wr('h04, (3 << 3) | 2, 0);
        rd('h18, v); chk(v == 1, "R6 flag held after valid write", v, 1);
        wr('h18, 1, 0);
        rd('h18, v); chk(v == 0, "R6 flag cleared", v, 0);
        run(30, 6, 2, 1, 1, 0);

        // R5 invalid while gated does not raise the flag
        wr('h14, 1, 0);
        wr('h04, 0, 0);
        run(10, 1, 2, 0, 0, 0);
        rd('h18, v); chk(v == 0, "R5 no flag while gated", v, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule